// File: doc/BRIEF.md
# MOESI Line State Controller

This block holds the coherence state of a single line in a private cache that joins a snooping coherence scheme. Two request sources feed it. The local processor side issues read, write and evict events. The interconnect side issues snoops of four kinds: a non-caching read, a shared read, a unique read and a unique write. For each accepted event the block moves its five-state register (Modified, Owned, Exclusive, Shared, Invalid). It also pulses flags that say whether a bus request must go out and of which kind, whether dirty data must be written back, and whether this copy must supply data to the snooper.

Every request carries a cache-attribute vector and a shareability-domain value. When the modifiable bit is clear, the request bypasses coherence entirely. When the domain value is illegal, the request raises an error pulse and is dropped. A local event and a snoop may arrive in the same cycle. In that case the snoop is applied first, and the local event then acts on the state the snoop leaves behind.

Top module: `moesi_line_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is sampled high, `state_o` is Invalid (encoding I=0, S=1, E=2, O=3, M=4) and `bus_req_o`, `wb_o`, `snp_data_o`, `err_o` are all 0.
- R2: A local read (op 0) on an Invalid line issues a shared request (`bus_req_o`=1). The line becomes Exclusive when `lcl_fill_unique_i` is 1 and Shared when it is 0. A read on any other state changes nothing and issues no request.
- R3: A local write (op 1) on Exclusive moves the line to Modified with no request. On Invalid, Shared or Owned it issues a unique request (`bus_req_o`=2) and moves the line to Modified. On Modified it changes nothing.
- R4: A local evict (op 2) on Modified or Owned pulses `wb_o` and moves the line to Invalid. On Exclusive or Shared it moves the line to Invalid without `wb_o`. Local op 3 does nothing.
- R5: A shared-read snoop (op 1) moves Modified to Owned and Exclusive to Shared, and leaves Owned, Shared and Invalid unchanged. It pulses `snp_data_o` when the line was Modified or Owned.
- R6: A unique-read snoop (op 2) or a unique-write snoop (op 3) moves the line to Invalid. It pulses `snp_data_o` when the line was Modified or Owned.
- R7: A read-once snoop (op 0) leaves the state unchanged and pulses `snp_data_o` when the line is Modified or Owned.
- R8: A request whose cache-attribute bit 1 is 0 is ignored. It changes no state and raises no request, write-back or supply flag.
- R9: A request with domain value 3 pulses `err_o` and is otherwise ignored, whatever its cache-attribute bits.
- R10: When a snoop and a local event are accepted in the same cycle, the snoop is applied first. The local event then acts on the resulting state, and the flags of both appear together.
- R11: All outputs are registered. The flags for an event appear in the cycle after it is sampled and last one cycle. A cycle with no valid request gives all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcl_vld_i | input | 1 | Local event valid |
| lcl_op_i | input | 2 | Local op: 0 read, 1 write, 2 evict, 3 none |
| lcl_cache_i | input | CACHE_W | Local cache attributes; bit MOD_BIT is modifiable |
| lcl_dom_i | input | 2 | Local shareability domain; 3 is illegal |
| lcl_fill_unique_i | input | 1 | A read miss fills as Exclusive when 1, Shared when 0 |
| snp_vld_i | input | 1 | Snoop valid |
| snp_op_i | input | 2 | Snoop op: 0 read-once, 1 shared read, 2 unique read, 3 unique write |
| snp_cache_i | input | CACHE_W | Snoop cache attributes; bit MOD_BIT is modifiable |
| snp_dom_i | input | 2 | Snoop shareability domain; 3 is illegal |
| state_o | output | 3 | Current line state |
| bus_req_o | output | 2 | Bus request: 0 none, 1 shared, 2 unique |
| wb_o | output | 1 | Dirty write-back needed |
| snp_data_o | output | 1 | Line supplies data to the snooper |
| err_o | output | 1 | Illegal domain seen |

## Verification
A snoop and a local event can be accepted in the same cycle. The bench provokes this by raising both valids on one edge with a dirty or exclusive line: a shared snoop with a write on Modified, a unique snoop with an evict on Modified, and a unique snoop with a read on Exclusive. It judges the result against a state computed by applying the snoop first and the local event second. It checks that the supply flag and the request or write-back flags come out together in the following cycle, and that a write-back never survives a snoop that already took the line away.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  localparam int DOM_W = 2;
  localparam logic [DOM_W-1:0] DOM_BAD = '1;

  typedef enum logic [2:0] {
    ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2, OP_NOP = 2'd3
  } lcl_op_t;

  typedef enum logic [1:0] {
    SN_ONCE = 2'd0, SN_SHR = 2'd1, SN_UNQ_RD = 2'd2, SN_UNQ_WR = 2'd3
  } snp_op_t;

  typedef enum logic [1:0] {
    RQ_NONE = 2'd0, RQ_SHARED = 2'd1, RQ_UNIQUE = 2'd2, RQ_RSVD = 2'd3
  } bus_req_t;
endpackage

// File: rtl/moesi_attr_gate.sv
module moesi_attr_gate
  import moesi_pkg::*;
#(
  parameter int CACHE_W = 4,
  parameter int MOD_BIT = 1
) (
  input  logic               vld_i,
  input  logic [CACHE_W-1:0] cache_i,
  input  logic [DOM_W-1:0]   dom_i,
  output logic               act_o,
  output logic               err_o
);
  logic dom_bad;
  logic unused_attr;

  assign unused_attr = ^cache_i;
  assign dom_bad = (dom_i == DOM_BAD);
  // illegal domain wins over the modifiable bypass
  assign err_o = vld_i & dom_bad;
  assign act_o = vld_i & ~dom_bad & cache_i[MOD_BIT];
endmodule

// File: rtl/moesi_snoop_xfer.sv
module moesi_snoop_xfer
  import moesi_pkg::*;
(
  input  logic     act_i,
  input  snp_op_t  op_i,
  input  line_st_t st_i,
  output line_st_t st_o,
  output logic     sup_o
);
  always_comb begin
    st_o  = st_i;
    sup_o = 1'b0;
    if (act_i) begin
      sup_o = (st_i == ST_M) || (st_i == ST_O);
      case (op_i)
        SN_SHR: begin
          if (st_i == ST_M) st_o = ST_O;
          else if (st_i == ST_E) st_o = ST_S;
        end
        SN_UNQ_RD, SN_UNQ_WR: st_o = ST_I;
        default: st_o = st_i;
      endcase
    end
  end
endmodule

// File: rtl/moesi_local_xfer.sv
module moesi_local_xfer
  import moesi_pkg::*;
(
  input  logic     act_i,
  input  lcl_op_t  op_i,
  input  logic     fill_unique_i,
  input  line_st_t st_i,
  output line_st_t st_o,
  output bus_req_t req_o,
  output logic     wb_o
);
  always_comb begin
    st_o  = st_i;
    req_o = RQ_NONE;
    wb_o  = 1'b0;
    if (act_i) begin
      case (op_i)
        OP_RD: begin
          if (st_i == ST_I) begin
            req_o = RQ_SHARED;
            st_o  = fill_unique_i ? ST_E : ST_S;
          end
        end
        OP_WR: begin
          case (st_i)
            ST_E: st_o = ST_M;
            ST_I, ST_S, ST_O: begin
              req_o = RQ_UNIQUE;
              st_o  = ST_M;
            end
            default: st_o = st_i;
          endcase
        end
        OP_EV: begin
          wb_o = (st_i == ST_M) || (st_i == ST_O);
          st_o = ST_I;
        end
        default: st_o = st_i;
      endcase
    end
  end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int CACHE_W = 4,
  parameter int MOD_BIT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lcl_vld_i,
  input  logic [1:0]         lcl_op_i,
  input  logic [CACHE_W-1:0] lcl_cache_i,
  input  logic [1:0]         lcl_dom_i,
  input  logic               lcl_fill_unique_i,
  input  logic               snp_vld_i,
  input  logic [1:0]         snp_op_i,
  input  logic [CACHE_W-1:0] snp_cache_i,
  input  logic [1:0]         snp_dom_i,
  output logic [2:0]         state_o,
  output logic [1:0]         bus_req_o,
  output logic               wb_o,
  output logic               snp_data_o,
  output logic               err_o
);
  localparam int NUM_CH = 2;
  localparam int CH_SNP = 0;
  localparam int CH_LCL = 1;

  logic [NUM_CH-1:0]  ch_vld, ch_act, ch_err;
  logic [CACHE_W-1:0] ch_cache [NUM_CH];
  logic [DOM_W-1:0]   ch_dom   [NUM_CH];

  assign ch_vld[CH_SNP]   = snp_vld_i;
  assign ch_vld[CH_LCL]   = lcl_vld_i;
  assign ch_cache[CH_SNP] = snp_cache_i;
  assign ch_cache[CH_LCL] = lcl_cache_i;
  assign ch_dom[CH_SNP]   = snp_dom_i;
  assign ch_dom[CH_LCL]   = lcl_dom_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_gate
    moesi_attr_gate #(.CACHE_W(CACHE_W), .MOD_BIT(MOD_BIT)) u_gate (
      .vld_i   (ch_vld[g]),
      .cache_i (ch_cache[g]),
      .dom_i   (ch_dom[g]),
      .act_o   (ch_act[g]),
      .err_o   (ch_err[g])
    );
  end

  line_st_t state_q, st_mid, st_nxt;
  bus_req_t req_nxt, req_q;
  logic     sup_nxt, wb_nxt, sup_q, wb_q, err_q;

  // snoop first, local event acts on what the snoop leaves
  moesi_snoop_xfer u_snp (
    .act_i (ch_act[CH_SNP]),
    .op_i  (snp_op_t'(snp_op_i)),
    .st_i  (state_q),
    .st_o  (st_mid),
    .sup_o (sup_nxt)
  );

  moesi_local_xfer u_lcl (
    .act_i         (ch_act[CH_LCL]),
    .op_i          (lcl_op_t'(lcl_op_i)),
    .fill_unique_i (lcl_fill_unique_i),
    .st_i          (st_mid),
    .st_o          (st_nxt),
    .req_o         (req_nxt),
    .wb_o          (wb_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_I;
      req_q   <= RQ_NONE;
      sup_q   <= 1'b0;
      wb_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= st_nxt;
      req_q   <= req_nxt;
      sup_q   <= sup_nxt;
      wb_q    <= wb_nxt;
      err_q   <= |ch_err;
    end
  end

  assign state_o    = state_q;
  assign bus_req_o  = req_q;
  assign wb_o       = wb_q;
  assign snp_data_o = sup_q;
  assign err_o      = err_q;

  p_silent_up_r3: assert property (@(posedge clk) disable iff (rst)
    (lcl_vld_i && lcl_cache_i[MOD_BIT] && lcl_dom_i != DOM_BAD &&
     lcl_op_i == 2'd1 && state_q == ST_E && !snp_vld_i)
    |=> (state_q == ST_M && req_q == RQ_NONE));

  p_wb_dirty_r4: assert property (@(posedge clk) disable iff (rst)
    wb_q |-> ($past(state_q) == ST_M || $past(state_q) == ST_O));

  p_sup_dirty_r5: assert property (@(posedge clk) disable iff (rst)
    sup_q |-> ($past(state_q) == ST_M || $past(state_q) == ST_O));

  p_unique_inv_r6: assert property (@(posedge clk) disable iff (rst)
    (snp_vld_i && snp_cache_i[MOD_BIT] && snp_dom_i != DOM_BAD &&
     snp_op_i[1] && !lcl_vld_i) |=> (state_q == ST_I));

  p_once_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (snp_vld_i && snp_op_i == 2'd0 && !lcl_vld_i) |=> $stable(state_q));

  p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    (lcl_vld_i && !lcl_cache_i[MOD_BIT] && !snp_vld_i)
    |=> ($stable(state_q) && req_q == RQ_NONE && !wb_q));

  p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (snp_vld_i && snp_dom_i == DOM_BAD && !lcl_vld_i)
    |=> ($stable(state_q) && err_q && !sup_q));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!snp_vld_i && !lcl_vld_i)
    |=> ($stable(state_q) && req_q == RQ_NONE && !wb_q && !sup_q && !err_q));
endmodule

// File: tb/moesi_line_ctrl_bench.sv
`timescale 1ns/1ps
module moesi_line_ctrl_bench;
  localparam int CACHE_W = 4;
  localparam int MOD_BIT = 1;
  localparam logic [CACHE_W-1:0] C_OK  = 4'b0010;
  localparam logic [CACHE_W-1:0] C_BYP = 4'b1101;
  localparam logic [1:0] D_OK = 2'b01;
  localparam logic [1:0] D_BAD = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lv = 0, lfu = 0, sv = 0;
  logic [1:0] lop = 0, ldom = D_OK, sop = 0, sdom = D_OK;
  logic [CACHE_W-1:0] lcache = C_OK, scache = C_OK;
  logic [2:0] state_o;
  logic [1:0] bus_req_o;
  logic wb_o, snp_data_o, err_o;

  always #2 clk = ~clk;

  moesi_line_ctrl #(.CACHE_W(CACHE_W), .MOD_BIT(MOD_BIT)) u_moesi_line_ctrl (
    .clk(clk), .rst(rst),
    .lcl_vld_i(lv), .lcl_op_i(lop), .lcl_cache_i(lcache), .lcl_dom_i(ldom),
    .lcl_fill_unique_i(lfu),
    .snp_vld_i(sv), .snp_op_i(sop), .snp_cache_i(scache), .snp_dom_i(sdom),
    .state_o(state_o), .bus_req_o(bus_req_o), .wb_o(wb_o),
    .snp_data_o(snp_data_o), .err_o(err_o)
  );

  // packed expectation: {state, req, wb, sup, err}
  logic [7:0] exp_q[$];
  string      tag_q[$];
  int n_vec = 0, n_bad = 0;
  logic [2:0] m_st = 3'd0;
  bit done = 0;

  function automatic logic [7:0] model(
      logic [2:0] s, logic l_v, logic [1:0] l_op, logic [CACHE_W-1:0] l_c,
      logic [1:0] l_d, logic l_fu, logic s_v, logic [1:0] s_op,
      logic [CACHE_W-1:0] s_c, logic [1:0] s_d);
    logic [2:0] st;
    logic [1:0] rq;
    logic w, sp, er, sa, la, dirty;
    st = s; rq = 0; w = 0; sp = 0;
    er = (s_v && s_d == 2'b11) || (l_v && l_d == 2'b11);
    sa = s_v && s_d != 2'b11 && s_c[MOD_BIT];
    la = l_v && l_d != 2'b11 && l_c[MOD_BIT];
    if (sa) begin
      dirty = (st == 3'd4) || (st == 3'd3);
      sp = dirty;
      if (s_op == 2'd1) begin
        if (st == 3'd4) st = 3'd3;
        else if (st == 3'd2) st = 3'd1;
      end else if (s_op != 2'd0) st = 3'd0;
    end
    if (la) begin
      if (l_op == 2'd0) begin
        if (st == 3'd0) begin rq = 2'd1; st = l_fu ? 3'd2 : 3'd1; end
      end else if (l_op == 2'd1) begin
        if (st != 3'd4 && st != 3'd2) rq = 2'd2;
        st = 3'd4;
      end else if (l_op == 2'd2) begin
        w = (st == 3'd4) || (st == 3'd3);
        st = 3'd0;
      end
    end
    return {st, rq, w, sp, er};
  endfunction

  task automatic apply(string tag, logic l_v, logic [1:0] l_op,
      logic [CACHE_W-1:0] l_c, logic [1:0] l_d, logic l_fu, logic s_v,
      logic [1:0] s_op, logic [CACHE_W-1:0] s_c, logic [1:0] s_d);
    logic [7:0] e;
    @(negedge clk);
    lv = l_v; lop = l_op; lcache = l_c; ldom = l_d; lfu = l_fu;
    sv = s_v; sop = s_op; scache = s_c; sdom = s_d;
    e = model(m_st, l_v, l_op, l_c, l_d, l_fu, s_v, s_op, s_c, s_d);
    m_st = e[7:5];
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic lcl(string tag, logic [1:0] op, logic fu);
    apply(tag, 1, op, C_OK, D_OK, fu, 0, 0, C_OK, D_OK);
  endtask

  task automatic snp(string tag, logic [1:0] op);
    apply(tag, 0, 0, C_OK, D_OK, 0, 1, op, C_OK, D_OK);
  endtask

  task automatic both(string tag, logic [1:0] l_op, logic fu, logic [1:0] s_op);
    apply(tag, 1, l_op, C_OK, D_OK, fu, 1, s_op, C_OK, D_OK);
  endtask

  task automatic idle(string tag);
    apply(tag, 0, 0, C_OK, D_OK, 0, 0, 0, C_OK, D_OK);
  endtask

  // monitor: one expectation per cycle, sampled mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [7:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {state_o, bus_req_o, wb_o, snp_data_o, err_o};
        n_vec++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: {st,req,wb,sup,err} actual=%b expected=%b", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if ({state_o, bus_req_o, wb_o, snp_data_o, err_o} !== 8'd0) begin
      n_bad++;
      $display("FAIL R1 reset: actual=%b expected=%b",
               {state_o, bus_req_o, wb_o, snp_data_o, err_o}, 8'd0);
    end
    rst = 1'b0;

    lcl("R2 read miss fill unique", 2'd0, 1);
    lcl("R3 write on E silent", 2'd1, 0);
    lcl("R3 read hit on M", 2'd0, 1);
    snp("R5 shared snoop on M", 2'd1);
    snp("R5 shared snoop on O", 2'd1);
    lcl("R3 write on O unique req", 2'd1, 0);
    lcl("R4 evict M writeback", 2'd2, 0);
    lcl("R2 read miss fill shared", 2'd0, 0);
    snp("R5 shared snoop on S", 2'd1);
    lcl("R3 write on S unique req", 2'd1, 0);
    snp("R7 read-once on M", 2'd0);
    snp("R6 unique read snoop on M", 2'd2);
    snp("R6 snoop on I", 2'd3);
    lcl("R2 read miss to E", 2'd0, 1);
    snp("R5 shared snoop on E", 2'd1);
    snp("R7 read-once on S", 2'd0);
    snp("R6 unique write snoop on S", 2'd3);
    lcl("R2 read miss to E", 2'd0, 1);
    snp("R6 unique write snoop on E", 2'd3);
    lcl("R4 evict on I", 2'd2, 0);
    lcl("R2 read miss to S", 2'd0, 0);
    lcl("R4 evict S silent", 2'd2, 0);
    lcl("R4 nop op", 2'd3, 0);
    apply("R8 bypassed local read", 1, 2'd0, C_BYP, D_OK, 1, 0, 0, C_OK, D_OK);
    idle("R8 state after bypass");
    lcl("R2 read miss to E", 2'd0, 1);
    lcl("R3 write on E", 2'd1, 0);
    apply("R8 bypassed unique snoop", 0, 0, C_OK, D_OK, 0, 1, 2'd2, C_BYP, D_OK);
    apply("R9 snoop illegal domain", 0, 0, C_OK, D_OK, 0, 1, 2'd3, C_OK, D_BAD);
    apply("R9 evict illegal domain", 1, 2'd2, C_OK, D_BAD, 0, 0, 0, C_OK, D_OK);
    apply("R9 illegal domain with bypass", 1, 2'd2, C_BYP, D_BAD, 0, 0, 0, C_OK, D_OK);
    idle("R11 idle after error");
    snp("R5 shared snoop M to O", 2'd1);
    lcl("R4 evict O writeback", 2'd2, 0);
    lcl("R2 read miss to E", 2'd0, 1);
    lcl("R3 write on E", 2'd1, 0);
    both("R10 shared snoop plus write on M", 2'd1, 0, 2'd1);
    both("R10 unique snoop plus evict on M", 2'd2, 0, 2'd2);
    lcl("R2 read miss to E", 2'd0, 1);
    both("R10 unique snoop plus read on E", 2'd0, 0, 2'd2);
    both("R10 read-once plus evict on S", 2'd2, 0, 2'd0);
    apply("R10 illegal snoop with local read", 1, 2'd0, C_OK, D_OK, 1, 1, 2'd2, C_OK, D_BAD);
    idle("R11 flags clear");
    idle("R11 idle again");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R11: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule